// File: doc/BRIEF.md
# Line-State Debounce Filter

This block qualifies slow digital status inputs on a telephone line-interface controller. It handles two groups of inputs. The first group holds the hook and ground-key detector outputs. The second group holds general-purpose pins that can be set up as digital inputs. Every raw input first passes through a two-flop synchroniser. It is then sampled on a time base divided down from the system clock. A debounced level moves to a new value only after enough consecutive samples agree with that value.

The two groups use different timing rules. Each group has its own 4-bit timing code, loaded through a plain register write port.

- **Hook group:** the code sets how long the gap between samples is. The number of agreeing samples is fixed.
- **IO group:** the gap between samples is fixed. The code sets how many agreeing samples are needed.

On each qualified transition, the block raises a one-clock change strobe on the bit that matches the input index. An interrupt stage can consume these strobes. The strobes carry no handshake and cannot be back-pressured, so the consumer must take them in the cycle they appear. There is no data stream, so every port is a plain control or status pin.

Top module: `line_debounce`

## Requirements
- R1: While reset is held and in the first cycle after it is released, all debounced levels are 0, all change strobes are 0, and both timing codes are 0.
- R2: For a hook-group code n, the hook group samples once every (n+1) ticks of T = CLK_HZ/8000 clocks, which is 0.125 ms. A level takes a new raw value only on the 16th consecutive sample that differs from the current level. As a result, the flip comes more than 15(n+1)T clocks and at most 16(n+1)T+4 clocks after the raw input changes.
- R3: Any sample that equals the current level restarts the count. A raw pulse shorter than the minimum time leaves the level and the strobes untouched.
- R4: With hook code 0111, which gives a 1 ms gap between samples, a raw pulse of 15 ms on a hook input is rejected and raises no strobe.
- R5: The IO group samples every 4T clocks, which is 0.5 ms. For an IO code n, the group needs 5+4n consecutive differing samples. The flip comes more than (4+4n)·4T clocks and at most (5+4n)·4T+4 clocks after the raw change.
- R6: A qualified transition in either direction raises the strobe bit of that input's index for exactly one clock. The strobe rises in the same cycle the level changes. The bits of other inputs are not affected.
- R7: An IO pin whose io_is_input bit is 0 bypasses the filter. Its io_level bit follows the raw pin within 3 clocks and never raises a strobe.
- R8: A write with cfg_we=1 loads cfg_code into the hook code when cfg_sel=0, or into the IO code when cfg_sel=1. The write clears the running counts of that group and keeps its current levels. It also blocks any strobe of that group in the next cycle. The new code governs the qualification that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Timing-code write strobe |
| cfg_sel | input | 1 | Code select: 0 = hook group, 1 = IO group |
| cfg_code | input | 4 | Timing code to load |
| hk_raw | input | NHK | Raw hook and ground-key detector outputs |
| io_raw | input | NIO | Raw general-purpose pin levels |
| io_is_input | input | NIO | 1 = pin is a digital input and is filtered |
| hk_level | output | NHK | Debounced hook-group levels |
| hk_chg | output | NHK | One-clock change strobes, hook group |
| io_level | output | NIO | Debounced (or bypassed) IO levels |
| io_chg | output | NIO | One-clock change strobes, IO group |

## Verification
A stuck or miscounting qualification counter shows at the ports as a level flip that falls outside the R2 or R5 window. The tests pin down the lower and upper edges of that window to within a few clocks, for the shortest code, a middle code and the longest code. A counter that is not restarted by a matching sample, or not cleared by a code write, lets a short pulse, the 15 ms pulse or a partly counted stretch flip the level too early. That error becomes visible within one sampling interval of the minimum time. A wrong strobe shows in the same cycle as the level change, because strobes and levels are checked against each other on every clock.

// File: rtl/ldb_pkg.sv
package ldb_pkg;
  typedef enum logic { GRP_HOOK = 1'b0, GRP_IO = 1'b1 } grp_e;

  localparam int CODE_W    = 4;
  localparam int CNT_W     = 7;
  localparam int HK_SAMPLES = 16;
  localparam int IO_BASE    = 5;
  localparam int IO_STEP    = 4;
  localparam int IO_DIV     = 4;   // coarse tick = IO_DIV fine ticks

  function automatic logic [CNT_W-1:0] io_need_m1(input logic [CODE_W-1:0] code);
    return CNT_W'(IO_BASE - 1) + CNT_W'(code) * CNT_W'(IO_STEP);
  endfunction
endpackage

// File: rtl/ldb_sync.sv
module ldb_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/ldb_timebase.sv
module ldb_timebase #(
  parameter int TICK_CYC = 2048,
  parameter int SUB_DIV  = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_fine,
  output logic tick_coarse
);
  localparam int PW = (TICK_CYC > 1) ? $clog2(TICK_CYC) : 1;
  localparam int SW = (SUB_DIV > 1) ? $clog2(SUB_DIV) : 1;

  logic [PW-1:0] pre;
  logic [SW-1:0] sub;

  assign tick_fine   = (pre == PW'(TICK_CYC - 1));
  assign tick_coarse = tick_fine && (sub == SW'(SUB_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre <= '0;
      sub <= '0;
    end else begin
      pre <= tick_fine ? '0 : pre + 1'b1;
      if (tick_fine)
        sub <= (sub == SW'(SUB_DIV - 1)) ? '0 : sub + 1'b1;
    end
  end
endmodule

// File: rtl/ldb_cell.sv
module ldb_cell
  import ldb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             bypass,
  input  logic             smp,
  input  logic             din,
  input  logic [CNT_W-1:0] need_m1,
  output logic             lvl,
  output logic             chg
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      lvl <= 1'b0;
      chg <= 1'b0;
    end else begin
      chg <= 1'b0;
      if (clr) begin
        cnt <= '0;
      end else if (bypass) begin
        cnt <= '0;
        lvl <= din;
      end else if (smp) begin
        if (din == lvl) begin
          cnt <= '0;
        end else if (cnt >= need_m1) begin
          cnt <= '0;
          lvl <= din;
          chg <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/line_debounce.sv
module line_debounce
  import ldb_pkg::*;
#(
  parameter int CLK_HZ = 16_384_000,
  parameter int NHK    = 2,
  parameter int NIO    = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic           cfg_sel,
  input  logic [3:0]     cfg_code,
  input  logic [NHK-1:0] hk_raw,
  input  logic [NIO-1:0] io_raw,
  input  logic [NIO-1:0] io_is_input,
  output logic [NHK-1:0] hk_level,
  output logic [NHK-1:0] hk_chg,
  output logic [NIO-1:0] io_level,
  output logic [NIO-1:0] io_chg
);
  localparam int TICK_CYC = CLK_HZ / 8000;

  logic [CODE_W-1:0] hk_code, io_code, ivl_cnt;
  logic              tick_fine, tick_coarse, hk_smp, clr_hk, clr_io;
  logic [NHK-1:0]    hk_s;
  logic [NIO-1:0]    io_s;
  logic [CNT_W-1:0]  hk_need_m1, io_need;

  assign clr_hk     = cfg_we && (grp_e'(cfg_sel) == GRP_HOOK);
  assign clr_io     = cfg_we && (grp_e'(cfg_sel) == GRP_IO);
  assign hk_smp     = tick_fine && (ivl_cnt == hk_code);
  assign hk_need_m1 = CNT_W'(HK_SAMPLES - 1);
  assign io_need    = io_need_m1(io_code);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hk_code <= '0;
      io_code <= '0;
      ivl_cnt <= '0;
    end else begin
      if (clr_hk) hk_code <= cfg_code;
      if (clr_io) io_code <= cfg_code;
      if (clr_hk || hk_smp) ivl_cnt <= '0;
      else if (tick_fine)   ivl_cnt <= ivl_cnt + 1'b1;
    end
  end

  ldb_timebase #(.TICK_CYC(TICK_CYC), .SUB_DIV(IO_DIV)) u_tb (
    .clk(clk), .rst_n(rst_n), .tick_fine(tick_fine), .tick_coarse(tick_coarse)
  );

  ldb_sync #(.W(NHK)) u_sync_hk (.clk(clk), .rst_n(rst_n), .d(hk_raw), .q(hk_s));
  ldb_sync #(.W(NIO)) u_sync_io (.clk(clk), .rst_n(rst_n), .d(io_raw), .q(io_s));

  for (genvar i = 0; i < NHK; i++) begin : g_hk
    ldb_cell u_cell (
      .clk(clk), .rst_n(rst_n), .clr(clr_hk), .bypass(1'b0), .smp(hk_smp),
      .din(hk_s[i]), .need_m1(hk_need_m1), .lvl(hk_level[i]), .chg(hk_chg[i])
    );
  end

  for (genvar j = 0; j < NIO; j++) begin : g_io
    ldb_cell u_cell (
      .clk(clk), .rst_n(rst_n), .clr(clr_io), .bypass(!io_is_input[j]),
      .smp(tick_coarse), .din(io_s[j]), .need_m1(io_need),
      .lvl(io_level[j]), .chg(io_chg[j])
    );
  end
endmodule

// File: rtl/ldb_checker.sv
module ldb_checker #(
  parameter int NHK = 2,
  parameter int NIO = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cfg_we,
  input logic           cfg_sel,
  input logic [NIO-1:0] io_is_input,
  input logic [NHK-1:0] hk_level,
  input logic [NHK-1:0] hk_chg,
  input logic [NIO-1:0] io_level,
  input logic [NIO-1:0] io_chg
);
  always @(posedge clk)
    if (!rst_n) assert_reset_quiet_R1: assert (hk_chg == '0 && io_chg == '0);

  assert_hk_strobe_marks_flip_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hk_level ^ $past(hk_level)) == hk_chg);

  assert_io_strobe_marks_flip_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((io_level ^ $past(io_level)) & $past(io_is_input)) == io_chg);

  assert_bypass_no_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (io_chg & ~$past(io_is_input)) == '0);

  assert_hk_no_back_to_back_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (hk_chg & $past(hk_chg)) == '0);

  assert_io_no_back_to_back_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (io_chg & $past(io_chg)) == '0);

  assert_hk_write_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !cfg_sel) |=> hk_chg == '0);

  assert_io_write_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_sel) |=> io_chg == '0);
endmodule

bind line_debounce ldb_checker #(.NHK(NHK), .NIO(NIO)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
  .io_is_input(io_is_input), .hk_level(hk_level), .hk_chg(hk_chg),
  .io_level(io_level), .io_chg(io_chg)
);

// File: tb/line_debounce_test.sv
module line_debounce_test;
  localparam int NHK = 2;
  localparam int NIO = 4;
  localparam int T   = 10;      // clocks per 0.125 ms at CLK_HZ = 80000
  localparam int T2  = 4 * T;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           cfg_we = 1'b0, cfg_sel = 1'b0;
  logic [3:0]     cfg_code = '0;
  logic [NHK-1:0] hk_raw = '0;
  logic [NIO-1:0] io_raw = '0;
  logic [NIO-1:0] io_is_input = '1;
  logic [NHK-1:0] hk_level, hk_chg;
  logic [NIO-1:0] io_level, io_chg;

  int checks = 0, failures = 0;
  int hk_pulses [NHK];
  int io_pulses [NIO];
  bit done = 1'b0;

  always #2 clk = ~clk;

  line_debounce #(.CLK_HZ(80000), .NHK(NHK), .NIO(NIO)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_code(cfg_code), .hk_raw(hk_raw), .io_raw(io_raw),
    .io_is_input(io_is_input), .hk_level(hk_level), .hk_chg(hk_chg),
    .io_level(io_level), .io_chg(io_chg)
  );

  initial begin
    for (int i = 0; i < NHK; i++) hk_pulses[i] = 0;
    for (int i = 0; i < NIO; i++) io_pulses[i] = 0;
  end

  always @(negedge clk) begin
    for (int i = 0; i < NHK; i++) if (hk_chg[i]) hk_pulses[i]++;
    for (int i = 0; i < NIO; i++) if (io_chg[i]) io_pulses[i]++;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit lvl_of(input bit grp, input int idx);
    return grp ? io_level[idx] : hk_level[idx];
  endfunction

  function automatic int pulses_of(input bit grp, input int idx);
    return grp ? io_pulses[idx] : hk_pulses[idx];
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_code(input bit sel, input logic [3:0] code);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_code = code;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // drive raw input, confirm level holds through lo clocks, flips by hi clocks
  task automatic expect_flip(input bit grp, input int idx, input bit val,
                             input int lo, input int hi, input string req);
    int p0;
    bit old;
    @(negedge clk);
    old = lvl_of(grp, idx);
    p0  = pulses_of(grp, idx);
    if (grp) io_raw[idx] = val; else hk_raw[idx] = val;
    cyc(lo);
    check(lvl_of(grp, idx) == old, req, "level held before minimum", lvl_of(grp, idx), old);
    cyc(hi - lo);
    check(lvl_of(grp, idx) == val, req, "level flipped within window", lvl_of(grp, idx), val);
    check(pulses_of(grp, idx) == p0 + 1, "R6", "one strobe per flip", pulses_of(grp, idx), p0 + 1);
  endtask

  task automatic t_reset;
    cyc(1);
    check(hk_level == '0, "R1", "hk_level in reset", hk_level, 0);
    check(io_level == '0, "R1", "io_level in reset", io_level, 0);
    @(negedge clk) rst_n = 1'b1;
    check(hk_chg == '0 && io_chg == '0, "R1", "strobes after reset", {hk_chg, io_chg}, 0);
    check(hk_level == '0, "R1", "hk_level after release", hk_level, 0);
  endtask

  task automatic t_hook_code0;
    expect_flip(1'b0, 0, 1'b1, 15 * T - 1, 16 * T + 4, "R2");
    check(hk_level[1] == 1'b0 && hk_pulses[1] == 0, "R6", "other index untouched",
          hk_pulses[1], 0);
  endtask

  task automatic t_hook_glitch;
    int p0 = hk_pulses[0];
    @(negedge clk) hk_raw[0] = 1'b0;
    cyc(100);
    hk_raw[0] = 1'b1;
    cyc(300);
    check(hk_level[0] == 1'b1, "R3", "short pulse rejected", hk_level[0], 1);
    check(hk_pulses[0] == p0, "R3", "no strobe from short pulse", hk_pulses[0], p0);
    expect_flip(1'b0, 0, 1'b0, 15 * T - 1, 16 * T + 4, "R6");
  endtask

  task automatic t_hook_15ms;
    set_code(1'b0, 4'd7);
    @(negedge clk) hk_raw[1] = 1'b1;
    cyc(120 * T);                       // 15 ms
    hk_raw[1] = 1'b0;
    cyc(200 * T);
    check(hk_level[1] == 1'b0, "R4", "15 ms pulse rejected", hk_level[1], 0);
    check(hk_pulses[1] == 0, "R4", "no strobe from 15 ms pulse", hk_pulses[1], 0);
    expect_flip(1'b0, 1, 1'b1, 15 * 8 * T - 1, 16 * 8 * T + 4, "R2");
    set_code(1'b0, 4'd15);
    expect_flip(1'b0, 1, 1'b0, 15 * 16 * T - 1, 16 * 16 * T + 4, "R2");
  endtask

  task automatic t_code_write;
    set_code(1'b0, 4'd0);
    @(negedge clk) hk_raw[0] = 1'b1;
    cyc(100);
    set_code(1'b0, 4'd0);               // clears the partial count
    cyc(140);
    check(hk_level[0] == 1'b0, "R8", "count cleared by write", hk_level[0], 0);
    cyc(40);
    check(hk_level[0] == 1'b1, "R8", "qualifies after write", hk_level[0], 1);
    set_code(1'b0, 4'd0);
    cyc(5);
    check(hk_level[0] == 1'b1, "R8", "level kept across write", hk_level[0], 1);
  endtask

  task automatic t_io;
    expect_flip(1'b1, 0, 1'b1, 4 * T2 - 1, 5 * T2 + 4, "R5");
    set_code(1'b1, 4'd2);
    expect_flip(1'b1, 1, 1'b1, 12 * T2 - 1, 13 * T2 + 4, "R5");
    set_code(1'b1, 4'd15);
    expect_flip(1'b1, 2, 1'b1, 64 * T2 - 1, 65 * T2 + 4, "R5");
  endtask

  task automatic t_bypass;
    int p0 = io_pulses[3];
    @(negedge clk) io_is_input[3] = 1'b0;
    cyc(2);
    io_raw[3] = 1'b1;
    cyc(3);
    check(io_level[3] == 1'b1, "R7", "bypass follows rise", io_level[3], 1);
    io_raw[3] = 1'b0;
    cyc(3);
    check(io_level[3] == 1'b0, "R7", "bypass follows fall", io_level[3], 0);
    check(io_pulses[3] == p0, "R7", "no strobe in bypass", io_pulses[3], p0);
  endtask

  initial begin
    t_reset();
    t_hook_code0();
    t_hook_glitch();
    t_hook_15ms();
    t_code_write();
    t_io();
    t_bypass();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule